// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a 16-bit segmented processor core that carries out the hardware steps of taking an interrupt and of leaving its handler. A requester supplies a one-cycle request pulse together with a source selector and an 8-bit immediate code. The sequencer resolves the vector type from these inputs. It then stores FLAGS, CS and IP on the stack, fetches the handler's offset and segment from the vector table at the bottom of physical memory, and loads them into IP and CS. A one-cycle return command runs the reverse steps: it pops IP, CS and FLAGS so that execution resumes where it was interrupted.

The register file stays outside the block. The sequencer samples FLAGS, CS, IP and SP through read ports when it accepts work, and updates them through write-enable/data pairs. SS is read directly to form stack addresses, which are SS×16+SP. All memory traffic uses one word-wide port. The port holds its request until the memory signals ready in the same cycle.

States: IDLE (waits for work); PUSH_FL, PUSH_CS, PUSH_IP (three stack writes); VEC_OFF, VEC_SEG (two table reads); LOAD (writes CS and IP, marks completion); POP_IP, POP_CS, POP_FL (three stack reads); RESTORE (writes FLAGS, CS and IP, marks completion). Transitions:
- IDLE goes to PUSH_FL when a request is taken, or to POP_IP when a return is taken.
- Each access state advances to the next state on a ready beat.
- PUSH_IP goes to VEC_OFF.
- VEC_SEG goes to LOAD.
- POP_FL goes to RESTORE.
- LOAD and RESTORE return to IDLE unconditionally.

Top module: `intr_seq`

## Requirements
- R1: The vector type depends on `req_src_i`. Code 0 takes `req_type_i`. Code 1 (divide overflow) gives type 0, code 2 (single-step) gives type 1, and code 3 (overflow-check) gives type 4.
- R2: Entry writes three stack words in this order: FLAGS, then CS, then IP. Before each write SP is lowered by 2, and the word goes to physical address SS×16+SP. Each new SP value is written back through the SP write port in the cycle of that write.
- R3: After the pushes, entry reads byte address 4n and then 4n+2, where n is the type. Every vector read lies inside bytes 0x000–0x3FF.
- R4: When entry completes, IP holds the word read from 4n and CS holds the word read from 4n+2.
- R5: In the same cycle as the FLAGS push, FLAGS is rewritten with bit 9 (interrupt enable) and bit 8 (trap) cleared. All other bits keep their values.
- R6: A return reads IP, then CS, then FLAGS from SS×16+SP, raising SP by 2 after each read. It then writes all three registers, which restores the state saved by the matching entry.
- R7: While `mem_req_o` is high and `mem_rdy_i` is low, the address, write enable and write data stay unchanged. The sequencer advances only on a ready beat.
- R8: `busy_o` is high from the cycle after a request or return is taken until the cycle in which the final register writes happen. It is low in IDLE.
- R9: `done_o` is a single-cycle pulse, raised once for each completed entry or return.
- R10: When a request and a return are both waiting, the request is served first and the return afterwards.
- R11: A request or return that arrives while the sequencer is busy is kept and served after the current sequence.
- R12: During reset the block is idle: no busy, no done, no memory request and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle interrupt request pulse |
| req_src_i | input | 2 | Request source selector (see R1) |
| req_type_i | input | 8 | Immediate type code for software requests |
| ret_i | input | 1 | One-cycle return command pulse |
| flags_i | input | 16 | Current FLAGS value |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Current stack segment |
| sp_i | input | 16 | Current stack pointer |
| flags_we_o | output | 1 | FLAGS write enable |
| flags_wd_o | output | 16 | FLAGS write data |
| cs_we_o | output | 1 | CS write enable |
| cs_wd_o | output | 16 | CS write data |
| ip_we_o | output | 1 | IP write enable |
| ip_wd_o | output | 16 | IP write data |
| sp_we_o | output | 1 | SP write enable |
| sp_wd_o | output | 16 | SP write data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Memory write word |
| mem_rdata_i | input | 16 | Memory read word, valid with ready |
| mem_rdy_i | input | 1 | Memory ready, completes the access |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is several pieces of work queued behind a running sequence. This includes a request and a return waiting together when the sequencer goes idle, and a return that must pop the frame of a nested second entry rather than the first. The stimulus raises a request and a return in the same cycle. It also fires a return and then a second request a few cycles into a running entry, while the memory model inserts random wait states. The reference model predicts the service order (request first) and the exact stream of accesses. Every ready beat is compared against that prediction.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int DATA_W     = 16;
    localparam int TYPE_W     = 8;
    localparam int SEG_SHIFT  = 4;
    localparam int ADDR_W     = DATA_W + SEG_SHIFT;
    localparam int SRC_W      = 2;
    localparam int IE_BIT     = 9;
    localparam int TRAP_BIT   = 8;

    localparam int TYPE_DIVIDE = 0;
    localparam int TYPE_STEP   = 1;
    localparam int TYPE_OVFCHK = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_SOFT   = 2'd0,
        SRC_DIVIDE = 2'd1,
        SRC_STEP   = 2'd2,
        SRC_OVFCHK = 2'd3
    } irq_src_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VEC_OFF,
        ST_VEC_SEG,
        ST_LOAD,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL,
        ST_RESTORE
    } seq_state_e;

endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_pkg::*;
#(
    parameter int TW = TYPE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [1:0]    req_src_i,
    input  logic [TW-1:0] req_type_i,
    input  logic          ret_i,
    input  logic          take_req_i,
    input  logic          take_ret_i,
    output logic          req_pend_o,
    output logic          ret_pend_o,
    output logic [TW-1:0] pend_type_o
);

    logic [TW-1:0] resolved_type;
    logic          req_slot_free;

    always_comb begin
        unique case (irq_src_e'(req_src_i))
            SRC_DIVIDE: resolved_type = TW'(TYPE_DIVIDE);
            SRC_STEP:   resolved_type = TW'(TYPE_STEP);
            SRC_OVFCHK: resolved_type = TW'(TYPE_OVFCHK);
            default:    resolved_type = req_type_i;
        endcase
    end

    assign req_slot_free = !req_pend_o || take_req_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_pend_o  <= 1'b0;
            ret_pend_o  <= 1'b0;
            pend_type_o <= '0;
        end else begin
            if (req_i && req_slot_free) begin
                req_pend_o  <= 1'b1;
                pend_type_o <= resolved_type;
            end else if (take_req_i) begin
                req_pend_o  <= 1'b0;
            end
            if (ret_i) begin
                ret_pend_o <= 1'b1;
            end else if (take_ret_i) begin
                ret_pend_o <= 1'b0;
            end
        end
    end

    // R10: with both waiting, the request wins
    a_r10_req_before_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pend_o && ret_pend_o && (take_req_i || take_ret_i)) |-> take_req_i);

    // R11: a waiting return survives until it is taken
    a_r11_ret_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pend_o && !take_ret_i) |=> ret_pend_o);

    // R11: a waiting request survives until it is taken
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pend_o && !take_req_i) |=> req_pend_o);

endmodule

// File: rtl/intr_addr_gen.sv
module intr_addr_gen
    import intr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = TYPE_W,
    parameter int SH = SEG_SHIFT
) (
    input  logic [DW-1:0]    seg_i,
    input  logic [DW-1:0]    off_i,
    input  logic [TW-1:0]    vtype_i,
    input  logic             vec_sel_i,
    input  logic             vec_hi_i,
    output logic [DW+SH-1:0] addr_o
);

    localparam int AW = DW + SH;

    logic [AW-1:0] stack_addr;
    logic [AW-1:0] table_addr;

    assign stack_addr = {seg_i, {SH{1'b0}}} + {{SH{1'b0}}, off_i};
    assign table_addr = {{(AW-TW-2){1'b0}}, vtype_i, vec_hi_i, 1'b0};
    assign addr_o     = vec_sel_i ? table_addr : stack_addr;

endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
    import intr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = TYPE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_pend_i,
    input  logic          ret_pend_i,
    input  logic [TW-1:0] pend_type_i,
    input  logic [DW-1:0] flags_i,
    input  logic [DW-1:0] cs_i,
    input  logic [DW-1:0] ip_i,
    input  logic [DW-1:0] sp_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          mem_rdy_i,
    output logic          take_req_o,
    output logic          take_ret_o,
    output logic [TW-1:0] vtype_o,
    output logic [DW-1:0] stk_off_o,
    output logic          vec_sel_o,
    output logic          vec_hi_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          flags_we_o,
    output logic [DW-1:0] flags_wd_o,
    output logic          cs_we_o,
    output logic [DW-1:0] cs_wd_o,
    output logic          ip_we_o,
    output logic [DW-1:0] ip_wd_o,
    output logic          sp_we_o,
    output logic [DW-1:0] sp_wd_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [DW-1:0] STEP     = DW'(2);
    localparam logic [DW-1:0] HOLD_OFF = ~((DW'(1) << IE_BIT) | (DW'(1) << TRAP_BIT));

    seq_state_e state_q, state_d;

    logic [DW-1:0] r_flags, r_cs, r_ip, r_sp;
    logic [DW-1:0] r_new_fl, r_new_cs, r_new_ip;
    logic [TW-1:0] r_type;
    logic          is_push, is_pop, is_vec, access, beat;

    assign is_push = (state_q == ST_PUSH_FL) || (state_q == ST_PUSH_CS) || (state_q == ST_PUSH_IP);
    assign is_pop  = (state_q == ST_POP_IP)  || (state_q == ST_POP_CS)  || (state_q == ST_POP_FL);
    assign is_vec  = (state_q == ST_VEC_OFF) || (state_q == ST_VEC_SEG);
    assign access  = is_push || is_pop || is_vec;
    assign beat    = access && mem_rdy_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_pend_i)      state_d = ST_PUSH_FL;
                else if (ret_pend_i) state_d = ST_POP_IP;
            end
            ST_PUSH_FL: if (mem_rdy_i) state_d = ST_PUSH_CS;
            ST_PUSH_CS: if (mem_rdy_i) state_d = ST_PUSH_IP;
            ST_PUSH_IP: if (mem_rdy_i) state_d = ST_VEC_OFF;
            ST_VEC_OFF: if (mem_rdy_i) state_d = ST_VEC_SEG;
            ST_VEC_SEG: if (mem_rdy_i) state_d = ST_LOAD;
            ST_LOAD:                   state_d = ST_IDLE;
            ST_POP_IP:  if (mem_rdy_i) state_d = ST_POP_CS;
            ST_POP_CS:  if (mem_rdy_i) state_d = ST_POP_FL;
            ST_POP_FL:  if (mem_rdy_i) state_d = ST_RESTORE;
            ST_RESTORE:                state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_flags  <= '0;
            r_cs     <= '0;
            r_ip     <= '0;
            r_sp     <= '0;
            r_type   <= '0;
            r_new_fl <= '0;
            r_new_cs <= '0;
            r_new_ip <= '0;
        end else if (state_q == ST_IDLE) begin
            if (req_pend_i || ret_pend_i) begin
                r_flags <= flags_i;
                r_cs    <= cs_i;
                r_ip    <= ip_i;
                r_sp    <= sp_i;
                r_type  <= pend_type_i;
            end
        end else if (beat) begin
            if (is_push) r_sp <= r_sp - STEP;
            if (is_pop)  r_sp <= r_sp + STEP;
            unique case (state_q)
                ST_VEC_OFF, ST_POP_IP: r_new_ip <= mem_rdata_i;
                ST_VEC_SEG, ST_POP_CS: r_new_cs <= mem_rdata_i;
                ST_POP_FL:             r_new_fl <= mem_rdata_i;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        take_req_o  = (state_q == ST_IDLE) && req_pend_i;
        take_ret_o  = (state_q == ST_IDLE) && !req_pend_i && ret_pend_i;
        vtype_o     = r_type;
        vec_sel_o   = is_vec;
        vec_hi_o    = (state_q == ST_VEC_SEG);
        stk_off_o   = is_push ? (r_sp - STEP) : r_sp;
        mem_req_o   = access;
        mem_we_o    = is_push;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_PUSH_FL: mem_wdata_o = r_flags;
            ST_PUSH_CS: mem_wdata_o = r_cs;
            ST_PUSH_IP: mem_wdata_o = r_ip;
            default:    mem_wdata_o = '0;
        endcase
        sp_we_o    = beat && (is_push || is_pop);
        sp_wd_o    = is_push ? (r_sp - STEP) : (r_sp + STEP);
        flags_we_o = ((state_q == ST_PUSH_FL) && mem_rdy_i) || (state_q == ST_RESTORE);
        flags_wd_o = (state_q == ST_RESTORE) ? r_new_fl : (r_flags & HOLD_OFF);
        cs_we_o    = (state_q == ST_LOAD) || (state_q == ST_RESTORE);
        ip_we_o    = cs_we_o;
        cs_wd_o    = r_new_cs;
        ip_wd_o    = r_new_ip;
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_LOAD) || (state_q == ST_RESTORE);
    end

    // R9: completion lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: completion happens while still marked busy, and idle follows
    a_r8_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R8: work taken in idle raises busy on the next cycle
    a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req_o || take_ret_o) |=> busy_o);

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = TYPE_W,
    parameter int SH = SEG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [1:0]       req_src_i,
    input  logic [TW-1:0]    req_type_i,
    input  logic             ret_i,
    input  logic [DW-1:0]    flags_i,
    input  logic [DW-1:0]    cs_i,
    input  logic [DW-1:0]    ip_i,
    input  logic [DW-1:0]    ss_i,
    input  logic [DW-1:0]    sp_i,
    output logic             flags_we_o,
    output logic [DW-1:0]    flags_wd_o,
    output logic             cs_we_o,
    output logic [DW-1:0]    cs_wd_o,
    output logic             ip_we_o,
    output logic [DW-1:0]    ip_wd_o,
    output logic             sp_we_o,
    output logic [DW-1:0]    sp_wd_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [DW+SH-1:0] mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    input  logic             mem_rdy_i,
    output logic             busy_o,
    output logic             done_o
);

    localparam int AW = DW + SH;

    logic          req_pend, ret_pend, take_req, take_ret;
    logic [TW-1:0] pend_type, vtype;
    logic [DW-1:0] stk_off;
    logic          vec_sel, vec_hi;

    intr_arbiter #(.TW(TW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .req_src_i  (req_src_i),
        .req_type_i (req_type_i),
        .ret_i      (ret_i),
        .take_req_i (take_req),
        .take_ret_i (take_ret),
        .req_pend_o (req_pend),
        .ret_pend_o (ret_pend),
        .pend_type_o(pend_type)
    );

    intr_fsm #(.DW(DW), .TW(TW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pend_i (req_pend),
        .ret_pend_i (ret_pend),
        .pend_type_i(pend_type),
        .flags_i    (flags_i),
        .cs_i       (cs_i),
        .ip_i       (ip_i),
        .sp_i       (sp_i),
        .mem_rdata_i(mem_rdata_i),
        .mem_rdy_i  (mem_rdy_i),
        .take_req_o (take_req),
        .take_ret_o (take_ret),
        .vtype_o    (vtype),
        .stk_off_o  (stk_off),
        .vec_sel_o  (vec_sel),
        .vec_hi_o   (vec_hi),
        .mem_req_o  (mem_req_o),
        .mem_we_o   (mem_we_o),
        .mem_wdata_o(mem_wdata_o),
        .flags_we_o (flags_we_o),
        .flags_wd_o (flags_wd_o),
        .cs_we_o    (cs_we_o),
        .cs_wd_o    (cs_wd_o),
        .ip_we_o    (ip_we_o),
        .ip_wd_o    (ip_wd_o),
        .sp_we_o    (sp_we_o),
        .sp_wd_o    (sp_wd_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    intr_addr_gen #(.DW(DW), .TW(TW), .SH(SH)) u_addr (
        .seg_i    (ss_i),
        .off_i    (stk_off),
        .vtype_i  (vtype),
        .vec_sel_i(vec_sel),
        .vec_hi_i (vec_hi),
        .addr_o   (mem_addr_o)
    );

    // R7: a pending access holds address, direction and data
    a_r7_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R3: vector reads stay inside the table
    a_r3_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        vec_sel |-> (mem_addr_o[AW-1:TW+2] == '0 && mem_addr_o[0] == 1'b0));

    // R2: each completed stack write lowers SP by one word
    a_r2_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_rdy_i) |-> (sp_we_o && sp_wd_o == sp_i - DW'(2)));

    // R6: each completed stack read raises SP by one word
    a_r6_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && !vec_sel && mem_rdy_i) |-> (sp_we_o && sp_wd_o == sp_i + DW'(2)));

    // R5: the FLAGS rewrite during entry drops interrupt enable and trap
    a_r5_mask_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we_o && mem_req_o) |-> (!flags_wd_o[IE_BIT] && !flags_wd_o[TRAP_BIT]));

    // R12: nothing moves while held in reset
    always_comb begin
        if (!rst_n) a_r12_quiet_reset: assert (!flags_we_o && !sp_we_o || $isunknown(flags_we_o));
    end

endmodule

// File: tb/intr_seq_bench.sv
module intr_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  req_src_i = 2'd0;
    logic [7:0]  req_type_i = 8'd0;
    logic        ret_i = 1'b0;
    logic [15:0] b_fl, b_cs, b_ip, b_ss, b_sp;
    logic        flags_we_o, cs_we_o, ip_we_o, sp_we_o;
    logic [15:0] flags_wd_o, cs_wd_o, ip_wd_o, sp_wd_o;
    logic        mem_req_o, mem_we_o;
    logic [19:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i = 16'h0;
    logic        mem_rdy_i = 1'b0;
    logic        busy_o, done_o;

    always #2 clk = ~clk;

    intr_seq u_intr_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_src_i(req_src_i),
        .req_type_i(req_type_i), .ret_i(ret_i),
        .flags_i(b_fl), .cs_i(b_cs), .ip_i(b_ip), .ss_i(b_ss), .sp_i(b_sp),
        .flags_we_o(flags_we_o), .flags_wd_o(flags_wd_o),
        .cs_we_o(cs_we_o), .cs_wd_o(cs_wd_o), .ip_we_o(ip_we_o), .ip_wd_o(ip_wd_o),
        .sp_we_o(sp_we_o), .sp_wd_o(sp_wd_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
        .busy_o(busy_o), .done_o(done_o)
    );

    localparam logic [15:0] INIT_FL = 16'h0346;
    localparam logic [15:0] INIT_CS = 16'h1234;
    localparam logic [15:0] INIT_IP = 16'h5678;
    localparam logic [15:0] INIT_SS = 16'h2000;
    localparam logic [15:0] INIT_SP = 16'h0100;

    typedef struct { bit we; int addr; logic [15:0] data; string tag; } acc_t;
    typedef struct { logic [15:0] fl, cs, ip, sp; string tag; } snap_t;

    acc_t        exp_q[$];
    snap_t       snap_q[$];
    logic [15:0] mem[int];
    logic [15:0] m_mem[int];
    logic [15:0] m_fl, m_cs, m_ip, m_sp;

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // ---------- behavioural reference model ----------
    function automatic int phys(input logic [15:0] off);
        return (int'(INIT_SS) * 16 + int'(off)) % (1 << 20);
    endfunction

    task automatic m_push(input logic [15:0] v, input string tag);
        acc_t a;
        m_sp = m_sp - 16'd2;
        a.we = 1; a.addr = phys(m_sp); a.data = v; a.tag = tag;
        m_mem[a.addr] = v;
        exp_q.push_back(a);
    endtask

    task automatic m_pop(output logic [15:0] v, input string tag);
        acc_t a;
        a.we = 0; a.addr = phys(m_sp); a.data = 16'h0; a.tag = tag;
        v = m_mem.exists(a.addr) ? m_mem[a.addr] : 16'h0;
        m_sp = m_sp + 16'd2;
        exp_q.push_back(a);
    endtask

    task automatic m_entry(input int t, input string tag);
        acc_t  a;
        snap_t s;
        m_push(m_fl, tag);
        m_push(m_cs, tag);
        m_push(m_ip, tag);
        a.we = 0; a.addr = 4 * t;     a.data = 16'h0; a.tag = tag; exp_q.push_back(a);
        a.addr = 4 * t + 2;                                        exp_q.push_back(a);
        m_fl = m_fl & ~16'h0300;
        m_ip = m_mem[4 * t];
        m_cs = m_mem[4 * t + 2];
        s.fl = m_fl; s.cs = m_cs; s.ip = m_ip; s.sp = m_sp; s.tag = tag;
        snap_q.push_back(s);
    endtask

    task automatic m_return(input string tag);
        snap_t s;
        m_pop(m_ip, tag);
        m_pop(m_cs, tag);
        m_pop(m_fl, tag);
        s.fl = m_fl; s.cs = m_cs; s.ip = m_ip; s.sp = m_sp; s.tag = tag;
        snap_q.push_back(s);
    endtask

    task automatic set_vec(input int t);
        mem[4 * t]       = 16'hA000 + 16'(t);
        mem[4 * t + 2]   = 16'hC000 + 16'(t);
        m_mem[4 * t]     = mem[4 * t];
        m_mem[4 * t + 2] = mem[4 * t + 2];
    endtask

    // ---------- register file outside the block ----------
    always @(posedge clk) begin
        if (!rst_n) begin
            b_fl <= INIT_FL; b_cs <= INIT_CS; b_ip <= INIT_IP;
            b_ss <= INIT_SS; b_sp <= INIT_SP;
        end else begin
            if (flags_we_o) b_fl <= flags_wd_o;
            if (cs_we_o)    b_cs <= cs_wd_o;
            if (ip_we_o)    b_ip <= ip_wd_o;
            if (sp_we_o)    b_sp <= sp_wd_o;
        end
    end

    // ---------- memory responder and per-clock comparison ----------
    bit          active = 0;
    int          lat = 0;
    logic [19:0] h_addr;
    logic        h_we;
    logic [15:0] h_wd;
    bit          chk_next = 0;
    bit          done_prev = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_rdy_i = 1'b0;
            active    = 0;
            check(!busy_o && !done_o && !mem_req_o, "R12", "idle in reset",
                  {busy_o, done_o, mem_req_o}, 0);
            check(!flags_we_o && !cs_we_o && !ip_we_o && !sp_we_o, "R12", "no writes in reset",
                  {flags_we_o, cs_we_o, ip_we_o, sp_we_o}, 0);
        end else begin
            if (mem_rdy_i) begin
                mem_rdy_i = 1'b0;
                active    = 0;
            end else if (active) begin
                check(mem_req_o && mem_addr_o == h_addr && mem_we_o == h_we
                      && (!h_we || mem_wdata_o == h_wd), "R7", "held access",
                      mem_addr_o, h_addr);
            end
            if (mem_req_o) begin
                if (!busy_o) check(0, "R8", "access outside busy", busy_o, 1);
                if (!active) begin
                    active = 1;
                    lat    = int'($urandom_range(0, 2));
                    h_addr = mem_addr_o; h_we = mem_we_o; h_wd = mem_wdata_o;
                end
                if (lat == 0) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2", "unexpected access", mem_addr_o, 0);
                    end else begin
                        acc_t e;
                        e = exp_q.pop_front();
                        check(mem_we_o == e.we && int'(mem_addr_o) == e.addr, e.tag,
                              "access address/direction", {mem_we_o, mem_addr_o},
                              {e.we, 20'(e.addr)});
                        if (e.we)
                            check(mem_wdata_o == e.data, e.tag, "pushed word",
                                  mem_wdata_o, e.data);
                    end
                    if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
                    else mem_rdata_i = mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 16'h0;
                    mem_rdy_i = 1'b1;
                end else begin
                    lat--;
                end
            end
            if (chk_next) begin
                snap_t s;
                chk_next = 0;
                if (snap_q.size() == 0) begin
                    check(0, "R9", "completion without work", 1, 0);
                end else begin
                    s = snap_q.pop_front();
                    check(b_ip == s.ip, s.tag, "IP after sequence", b_ip, s.ip);
                    check(b_cs == s.cs, s.tag, "CS after sequence", b_cs, s.cs);
                    check(b_fl == s.fl, s.tag, "FLAGS after sequence", b_fl, s.fl);
                    check(b_sp == s.sp, s.tag, "SP after sequence", b_sp, s.sp);
                end
            end
            if (done_o) begin
                check(!done_prev, "R9", "done single cycle", done_prev, 0);
                check(busy_o, "R8", "busy while completing", busy_o, 1);
                chk_next = 1;
            end
            done_prev = done_o;
        end
    end

    // ---------- watchdog ----------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------- stimulus ----------
    task automatic pulse_req(input logic [1:0] src, input logic [7:0] t);
        @(negedge clk);
        req_i = 1'b1; req_src_i = src; req_type_i = t;
        @(negedge clk);
        req_i = 1'b0; req_type_i = 8'h5A;
    endtask

    task automatic pulse_ret();
        @(negedge clk);
        ret_i = 1'b1;
        @(negedge clk);
        ret_i = 1'b0;
    endtask

    task automatic pulse_both(input logic [1:0] src, input logic [7:0] t);
        @(negedge clk);
        req_i = 1'b1; ret_i = 1'b1; req_src_i = src; req_type_i = t;
        @(negedge clk);
        req_i = 1'b0; ret_i = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while ((exp_q.size() != 0 || snap_q.size() != 0 || busy_o || chk_next) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n < 2000 && !busy_o, tag, "sequence finished", n, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        foreach (exp_q[i]) exp_q.delete(i);
        set_vec(0); set_vec(1); set_vec(4); set_vec(8'h37); set_vec(8'hFF);
        set_vec(8'h5A);
        m_fl = INIT_FL; m_cs = INIT_CS; m_ip = INIT_IP; m_sp = INIT_SP;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3/R4/R5: software request, immediate type 0x37
        m_entry(8'h37, "R2");
        pulse_req(2'd0, 8'h37);
        @(negedge clk);
        check(busy_o, "R8", "busy after taking request", busy_o, 1);
        wait_idle("R4");
        check(b_fl == (INIT_FL & ~16'h0300), "R5", "IE and trap cleared", b_fl, INIT_FL & ~16'h0300);
        check(b_ip == 16'hA037 && b_cs == 16'hC037, "R1", "soft type vector", {b_cs, b_ip}, 32'hC037A037);
        check(!busy_o, "R8", "idle after entry", busy_o, 0);

        // R6: return restores the interrupted point
        m_return("R6");
        pulse_ret();
        wait_idle("R6");
        check(b_fl == INIT_FL && b_cs == INIT_CS && b_ip == INIT_IP && b_sp == INIT_SP,
              "R6", "full restore", {b_fl, b_cs, b_ip, b_sp}, {INIT_FL, INIT_CS, INIT_IP, INIT_SP});

        // R1: divide overflow selects type 0 regardless of the immediate
        m_entry(0, "R1");
        pulse_req(2'd1, 8'h37);
        wait_idle("R1");
        m_return("R6");
        pulse_ret();
        wait_idle("R6");

        // R10: request and return in the same cycle, step source -> type 1
        m_entry(1, "R10");
        m_return("R10");
        pulse_both(2'd2, 8'h00);
        wait_idle("R10");

        // R11: overflow-check entry, then a return and a boundary request while busy
        m_entry(4, "R11");
        m_entry(8'hFF, "R3");
        m_return("R11");
        pulse_req(2'd3, 8'h00);
        repeat (2) @(negedge clk);
        pulse_ret();
        pulse_req(2'd0, 8'hFF);
        wait_idle("R11");
        check(b_ip == 16'hA004 && b_cs == 16'hC004, "R11", "nested frame popped",
              {b_cs, b_ip}, 32'hC004A004);
        m_return("R6");
        pulse_ret();
        wait_idle("R6");
        check(b_sp == INIT_SP && b_fl == INIT_FL, "R6", "stack balanced", {b_sp, b_fl}, {INIT_SP, INIT_FL});

        check(exp_q.size() == 0, "R2", "all predicted accesses seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule